// File: doc/BRIEF.md
# Core Power Mode Sequencer

This block moves a processor core between three power modes: run, idle and sleep. In run the core is fully active. In idle its clock is stopped but interrupts are still watched. In sleep all on-chip activity is shut down. A software-style command input asks for a target mode. An interrupt input wakes the core from idle or sleep. Every change of mode goes through a timed transition, and each transition has its own length.

The transition lengths are counted in clock cycles. By default they are derived from a clock-frequency parameter: 10 us between run and idle in either direction, 90 us to enter sleep from run or from idle, and 160 ms to leave sleep. Sleep always exits to run. A testbench may override the cycle counts with small values.

The outputs are the settled mode, a busy flag for a transition in progress, a core clock enable, a core power enable and a nominal power figure for monitoring. Commands have no back-pressure. A command that arrives while the block is busy, or one that the rules below refuse, is dropped without notice. The caller resends it once busy is low.

Top module: `dps_ctrl`

## Requirements
- R1: While and after reset (rst_n low, active low, synchronous), mode is run, busy is 0, clk_en and pwr_en are 1, and pwr_uw is 400000.
- R2: Mode codes are 0 = run, 1 = idle, 2 = sleep; code 3 is reserved. A command (cmd_valid high with cmd_mode) made while busy is 0 starts a transition, and busy is 1 after the next rising edge.
- R3: A transition keeps busy high for exactly LAT_FAST cycles between run and idle (either way), LAT_SLEEP cycles from run or idle into sleep, and LAT_WAKE cycles from sleep to run. mode switches to the target on the same edge where busy falls.
- R4: While busy is 1, commands and irq are ignored and mode keeps showing the source mode.
- R5: A command for the current mode, a command with code 3, and a command for idle while in sleep are all ignored: busy stays 0 and mode does not change.
- R6: irq high while busy is 0 and mode is idle or sleep starts a transition to run. It takes priority over a command in the same cycle. irq in run has no effect.
- R7: clk_en is 0 when settled in idle or sleep and during a transition from idle to sleep. It is 1 in run, during any transition out of run, and during any transition whose target is run.
- R8: pwr_en is 0 only while settled in sleep. It is 1 through the whole transition into sleep and the whole transition out of it.
- R9: pwr_uw gives the nominal power of the reported mode in microwatts: 400000 in run, 50000 in idle, 160 in sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Mode command present this cycle |
| cmd_mode | input | 2 | Requested mode code |
| irq | input | 1 | Wake interrupt |
| mode | output | 2 | Settled (source) mode code |
| busy | output | 1 | Transition in progress |
| clk_en | output | 1 | Core clock enable |
| pwr_en | output | 1 | Core power enable |
| pwr_uw | output | 20 | Nominal power of the reported mode, in microwatts |

## Verification
The assertions assume only that reset is held low for at least one edge and that every input has a known value at each rising edge. Beyond that, any mix of commands, reserved codes and interrupts is legal, including commands that arrive while busy. The stimulus drives all inputs at the falling edge and always to 0 or 1. Random commands cover all four codes, and interrupts arrive at any time. This exercises the drop, refusal and priority rules on every cycle.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_RSVD  = 2'd3
  } dps_mode_e;

  localparam int PW_W = 20;
  localparam logic [PW_W-1:0] PW_RUN_UW   = 20'd400000;
  localparam logic [PW_W-1:0] PW_IDLE_UW  = 20'd50000;
  localparam logic [PW_W-1:0] PW_SLEEP_UW = 20'd160;

  function automatic logic [PW_W-1:0] power_of(dps_mode_e m);
    case (m)
      MODE_RUN:   return PW_RUN_UW;
      MODE_IDLE:  return PW_IDLE_UW;
      default:    return PW_SLEEP_UW;
    endcase
  endfunction
endpackage

// File: rtl/dps_latency_timer.sv
module dps_latency_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dps_sequencer.sv
module dps_sequencer
  import dps_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int LAT_FAST  = 4,
  parameter int LAT_SLEEP = 8,
  parameter int LAT_WAKE  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_mode,
  input  logic             irq,
  input  logic             expired,
  output dps_mode_e        mode_q,
  output dps_mode_e        tgt_q,
  output logic             busy_q,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  dps_mode_e req;
  dps_mode_e nxt;
  logic      wake, legal;

  function automatic logic [CNT_W-1:0] lat_of(dps_mode_e src, dps_mode_e dst);
    int l;
    if (src == MODE_SLEEP)      l = LAT_WAKE;
    else if (dst == MODE_SLEEP) l = LAT_SLEEP;
    else                        l = LAT_FAST;
    return CNT_W'(l - 1);
  endfunction

  always_comb begin
    req   = dps_mode_e'(cmd_mode);
    wake  = irq && (mode_q != MODE_RUN);
    legal = cmd_valid && (req != MODE_RSVD) && (req != mode_q) &&
            !((mode_q == MODE_SLEEP) && (req == MODE_IDLE));
    nxt      = wake ? MODE_RUN : req;
    load     = !busy_q && (wake || legal);
    load_val = lat_of(mode_q, nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      tgt_q  <= MODE_RUN;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (expired) begin
        mode_q <= tgt_q;
        busy_q <= 1'b0;
      end
    end else if (load) begin
      tgt_q  <= nxt;
      busy_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dps_outputs.sv
module dps_outputs
  import dps_pkg::*;
(
  input  dps_mode_e       mode_q,
  input  dps_mode_e       tgt_q,
  input  logic            busy_q,
  output logic            clk_en,
  output logic            pwr_en,
  output logic [PW_W-1:0] pwr_uw
);
  logic exiting;

  always_comb begin
    exiting = busy_q && (tgt_q == MODE_RUN);
    clk_en  = (mode_q == MODE_RUN) || exiting;
    pwr_en  = (mode_q != MODE_SLEEP) || busy_q;
    pwr_uw  = power_of(mode_q);
  end
endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned LAT_FAST  = 32'((64'(CLK_HZ) * 64'd1)  / 64'd100_000),
  parameter int unsigned LAT_SLEEP = 32'((64'(CLK_HZ) * 64'd9)  / 64'd100_000),
  parameter int unsigned LAT_WAKE  = 32'((64'(CLK_HZ) * 64'd16) / 64'd100)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_mode,
  input  logic        irq,
  output logic [1:0]  mode,
  output logic        busy,
  output logic        clk_en,
  output logic        pwr_en,
  output logic [19:0] pwr_uw
);
  localparam int unsigned LAT_MAX_A = (LAT_FAST > LAT_SLEEP) ? LAT_FAST : LAT_SLEEP;
  localparam int unsigned LAT_MAX   = (LAT_MAX_A > LAT_WAKE) ? LAT_MAX_A : LAT_WAKE;
  localparam int CNT_W = $clog2(LAT_MAX + 1);

  dps_mode_e        mode_q, tgt_q;
  logic             busy_q, load, expired;
  logic [CNT_W-1:0] load_val;

  dps_sequencer #(
    .CNT_W(CNT_W), .LAT_FAST(int'(LAT_FAST)),
    .LAT_SLEEP(int'(LAT_SLEEP)), .LAT_WAKE(int'(LAT_WAKE))
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .irq(irq), .expired(expired), .mode_q(mode_q), .tgt_q(tgt_q),
    .busy_q(busy_q), .load(load), .load_val(load_val)
  );

  dps_latency_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  dps_outputs u_out (
    .mode_q(mode_q), .tgt_q(tgt_q), .busy_q(busy_q),
    .clk_en(clk_en), .pwr_en(pwr_en), .pwr_uw(pwr_uw)
  );

  assign mode = mode_q;
  assign busy = busy_q;
endmodule

// File: rtl/dps_ctrl_chk.sv
module dps_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [1:0]  mode,
  input logic        busy,
  input logic        clk_en,
  input logic        pwr_en,
  input logic [19:0] pwr_uw
);
  a_r3_mode_moves_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> $fell(busy));
  a_r4_mode_held_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $stable(mode));
  a_r5_no_sleep_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !($past(mode) == 2'd2 && mode == 2'd1));
  a_r6_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && irq && mode != 2'd0) |=> busy);
  a_r7_clk_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> !clk_en);
  a_r8_sleep_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !busy) |-> !pwr_en);
  a_r9_run_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (pwr_uw == 20'd400000));
endmodule

bind dps_ctrl dps_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .mode(mode), .busy(busy),
  .clk_en(clk_en), .pwr_en(pwr_en), .pwr_uw(pwr_uw)
);

// File: tb/dps_ctrl_tb.sv
module dps_ctrl_tb;
  localparam int LF = 3, LS = 5, LW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, irq = 1'b0;
  logic [1:0] cmd_mode = 2'd0;
  logic [1:0] mode;
  logic busy, clk_en, pwr_en;
  logic [19:0] pwr_uw;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench reference state
  logic [1:0] m_mode = 2'd0, m_tgt = 2'd0;
  logic       m_busy = 1'b0;
  int         m_cnt = 0;

  always #10 clk = ~clk;

  dps_ctrl #(.CLK_HZ(50_000_000), .LAT_FAST(LF), .LAT_SLEEP(LS), .LAT_WAKE(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .irq(irq),
    .mode(mode), .busy(busy), .clk_en(clk_en), .pwr_en(pwr_en), .pwr_uw(pwr_uw)
  );

  function automatic int lat(logic [1:0] s, logic [1:0] d);
    if (s == 2'd2) return LW;
    if (d == 2'd2) return LS;
    return LF;
  endfunction

  function automatic logic [19:0] exp_pw(logic [1:0] m);
    return (m == 2'd0) ? 20'd400000 : (m == 2'd1) ? 20'd50000 : 20'd160;
  endfunction

  function automatic logic exp_clk();
    return m_busy ? (m_mode == 2'd0 || m_tgt == 2'd0) : (m_mode == 2'd0);
  endfunction

  task automatic model_step();
    if (m_busy) begin
      if (m_cnt == 0) begin m_mode = m_tgt; m_busy = 1'b0; end
      else m_cnt--;
    end else if (irq && m_mode != 2'd0) begin
      m_tgt = 2'd0; m_busy = 1'b1; m_cnt = lat(m_mode, 2'd0) - 1;
    end else if (cmd_valid && cmd_mode != 2'd3 && cmd_mode != m_mode &&
                 !(m_mode == 2'd2 && cmd_mode == 2'd1)) begin
      m_tgt = cmd_mode; m_busy = 1'b1; m_cnt = lat(m_mode, cmd_mode) - 1;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3 mode", mode, m_mode);
    chk("R4 busy", busy, m_busy);
    chk("R7 clk_en", clk_en, exp_clk());
    chk("R8 pwr_en", pwr_en, !(m_mode == 2'd2 && !m_busy));
    chk("R9 pwr_uw", pwr_uw, exp_pw(m_mode));
  endtask

  // one cycle: drive at falling edge, step model at rising edge, check at next falling edge
  task automatic cyc(logic v, logic [1:0] c, logic i);
    cmd_valid = v; cmd_mode = c; irq = i;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle_cycles(int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 mode", mode, 0); chk("R1 busy", busy, 0);
    chk("R1 clk_en", clk_en, 1); chk("R1 pwr_en", pwr_en, 1);
    chk("R1 pwr_uw", pwr_uw, 400000);
    rst_n = 1'b1;

    // R2 run->idle accepted; R3 busy lasts LF cycles
    cyc(1'b1, 2'd1, 1'b0);
    chk("R2 busy after cmd", busy, 1);
    begin
      int n = 1;
      while (busy && n < 50) begin cyc(1'b0, 2'd0, 1'b0); if (busy) n++; end
      chk("R3 run->idle cycles", n, LF);
    end
    chk("R3 mode idle", mode, 1);
    // R5 same mode ignored
    cyc(1'b1, 2'd1, 1'b0); chk("R5 same mode", busy, 0);
    cyc(1'b1, 2'd3, 1'b0); chk("R5 reserved code", busy, 0);
    // R6 irq beats a same-cycle sleep command
    cyc(1'b1, 2'd2, 1'b1); chk("R6 irq priority busy", busy, 1);
    // R4 commands during busy ignored
    cyc(1'b1, 2'd2, 1'b0); chk("R4 mode held", mode, 1);
    idle_cycles(LF);
    chk("R6 woke to run", mode, 0);
    // R6 irq in run no effect
    cyc(1'b0, 2'd0, 1'b1); chk("R6 irq in run", busy, 0);
    // run->sleep, then idle request refused
    cyc(1'b1, 2'd2, 1'b0); idle_cycles(LS);
    chk("R8 sleep pwr off", pwr_en, 0);
    cyc(1'b1, 2'd1, 1'b0); chk("R5 sleep->idle refused", busy, 0);
    chk("R5 still sleep", mode, 2);
    // wake by command; R3 sleep->run takes LW
    cyc(1'b1, 2'd0, 1'b0);
    chk("R8 pwr on at exit", pwr_en, 1);
    chk("R7 clk on at exit", clk_en, 1);
    idle_cycles(LW - 1); chk("R3 still sleep", mode, 2);
    idle_cycles(1); chk("R3 back to run", mode, 0);

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      cyc(r < 35, 2'($urandom_range(0, 3)), $urandom_range(0, 99) < 8);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule